// File: doc/BRIEF.md
# Carry-accumulating feedback shift register keystream generator

This block produces one pseudo-random keystream bit per enabled clock. It pairs a shift register of `WIDTH` bits with a small integer carry register. The carry holds its value from one step to the next. On each step, the bits picked out by the `TAPS` mask are counted and added to the current carry. Bit 0 of that sum enters the register at its most significant end, while the register moves one place toward bit 0. The sum shifted right by one becomes the next carry.

The bit leaving at position 0 is the keystream bit. A load strobe writes a seed and a starting carry in one cycle. A clock enable lets the generator pause. The full register and carry values are visible for observation. A combinational flag marks the dead state, where the register and carry are both zero and the output stays at zero forever.

The carry register is `$clog2(NTAPS)+1` bits wide, where NTAPS is the number of set bits in `TAPS`. At that width the carry cannot overflow, whatever value is loaded into it.

Top module: `fcsr_keygen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `state` to `RESET_SEED` and `carry` to 0. Reset has priority over load and enable.
- R2: When `load` is high and `rst` is low, the next clock writes `seed` into `state` and `carry_in` into `carry`, whatever the value of `en`.
- R3: When `rst`, `load` and `en` are all low, `state` and `carry` keep their values.
- R4: On an enabled step (`en` high, `load` and `rst` low), `state` shifts one place toward bit 0. The new bit `WIDTH-1` is bit 0 of S, where S is the number of positions i with `TAPS[i]` and `state[i]` both 1, plus `carry`.
- R5: On an enabled step, the next `carry` equals S shifted right by one bit (integer S/2).
- R6: `ks_bit` always equals `state[0]`, the bit about to be shifted out.
- R7: `lockup` is high exactly when `state` and `carry` are both zero. An enabled step from that state stays in it.
- R8: A carry no greater than NTAPS stays no greater than NTAPS after an enabled step. A larger loaded carry never wraps the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Writes seed and carry_in on the next edge |
| seed | input | WIDTH | Shift register value to load |
| carry_in | input | CW | Carry value to load |
| en | input | 1 | Advances the generator one step |
| ks_bit | output | 1 | Keystream bit, register bit 0 |
| state | output | WIDTH | Current shift register contents |
| carry | output | CW | Current carry value |
| lockup | output | 1 | Register and carry both zero |

## Verification
The hardest condition to reach from the ports is a carry above NTAPS. The feedback on its own never drives the carry there, so only a load can put it there. The bench therefore loads the largest carry the width allows and then steps the generator, watching the carry fall back toward the normal range without wrapping. It also loads the all-zero dead state on purpose, which random seeds almost never produce, and it raises load together with enable to check that load wins.

// File: rtl/fcsr_keygen.sv
module fcsr_keygen #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'h8016,
  parameter logic [WIDTH-1:0] RESET_SEED = 16'h0001,
  localparam int NTAPS = $countones(TAPS),
  localparam int CW = $clog2(NTAPS) + 1,
  localparam int SW = CW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic [CW-1:0]    carry_in,
  input  logic             en,
  output logic             ks_bit,
  output logic [WIDTH-1:0] state,
  output logic [CW-1:0]    carry,
  output logic             lockup
);

  logic [SW-1:0] tsum;

  always_comb begin
    tsum = {1'b0, carry};
    for (int i = 0; i < WIDTH; i++)
      tsum = tsum + SW'(state[i] & TAPS[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RESET_SEED;
      carry <= '0;
    end else if (load) begin
      state <= seed;
      carry <= carry_in;
    end else if (en) begin
      state <= {tsum[0], state[WIDTH-1:1]};
      carry <= tsum[SW-1:1];
    end
  end

  assign ks_bit = state[0];
  assign lockup = (state == '0) && (carry == '0);

endmodule

module fcsr_keygen_chk #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'h8016,
  parameter logic [WIDTH-1:0] RESET_SEED = 16'h0001,
  localparam int NTAPS = $countones(TAPS),
  localparam int CW = $clog2(NTAPS) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [CW-1:0]    carry_in,
  input logic             en,
  input logic             ks_bit,
  input logic [WIDTH-1:0] state,
  input logic [CW-1:0]    carry,
  input logic             lockup
);

  // R1
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (state == RESET_SEED) && (carry == '0));

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (state == $past(seed)) && (carry == $past(carry_in)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state) && $stable(carry));

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && en) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));

  // R6
  out_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ks_bit == state[0]);

  // R7
  lockup_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (lockup && en && !load) |=> lockup);

  // R8
  carry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (carry <= CW'(NTAPS) && en && !load) |=> carry <= CW'(NTAPS));

endmodule

bind fcsr_keygen fcsr_keygen_chk #(.WIDTH(WIDTH), .TAPS(TAPS), .RESET_SEED(RESET_SEED)) u_chk (
  .clk(clk), .rst(rst), .load(load), .seed(seed), .carry_in(carry_in), .en(en),
  .ks_bit(ks_bit), .state(state), .carry(carry), .lockup(lockup));

// File: tb/fcsr_keygen_bench.sv
module fcsr_keygen_bench;
  localparam int WIDTH = 16;
  localparam logic [WIDTH-1:0] TAPS = 16'h8016;
  localparam logic [WIDTH-1:0] RSEED = 16'h0001;
  localparam int NT = 4;
  localparam int CW = 3;

  logic clk = 0, rst = 1, load = 0, en = 0;
  logic [WIDTH-1:0] seed = '0;
  logic [CW-1:0] carry_in = '0;
  logic ks_bit, lockup;
  logic [WIDTH-1:0] state;
  logic [CW-1:0] carry;

  int checks = 0, fails = 0;
  logic [WIDTH-1:0] m_state;
  int m_carry;

  always #4 clk = ~clk;

  fcsr_keygen #(.WIDTH(WIDTH), .TAPS(TAPS), .RESET_SEED(RSEED)) u_fcsr_keygen (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .carry_in(carry_in), .en(en),
    .ks_bit(ks_bit), .state(state), .carry(carry), .lockup(lockup));

  function automatic int step_sum(logic [WIDTH-1:0] s, int c);
    int t = c;
    for (int i = 0; i < WIDTH; i++) if (TAPS[i] && s[i]) t++;
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R4 state"}, 32'(state), 32'(m_state));
    chk({tag, " R5 carry"}, 32'(carry), 32'(m_carry));
    chk({tag, " R6 ks_bit"}, 32'(ks_bit), 32'(m_state[0]));
    chk({tag, " R7 lockup"}, 32'(lockup), 32'(m_state == 0 && m_carry == 0));
  endtask

  // drive at negedge, model the coming posedge
  task automatic drive(logic r, logic l, logic e, logic [WIDTH-1:0] sd, logic [CW-1:0] ci);
    int t;
    rst = r; load = l; en = e; seed = sd; carry_in = ci;
    if (r) begin m_state = RSEED; m_carry = 0; end
    else if (l) begin m_state = sd; m_carry = int'(ci); end
    else if (e) begin
      t = step_sum(m_state, m_carry);
      m_state = {t[0], m_state[WIDTH-1:1]};
      m_carry = t >> 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    @(negedge clk);
    drive(1, 0, 0, '0, '0);
    chk("R1 reset state", 32'(state), 32'(RSEED));
    chk("R1 reset carry", 32'(carry), 0);
    drive(1, 1, 1, 16'hffff, 3'd5);
    chk("R1 reset beats load", 32'(state), 32'(RSEED));
    drive(0, 1, 1, 16'hace1, 3'd2);
    chk("R2 load over enable state", 32'(state), 32'hace1);
    chk("R2 load over enable carry", 32'(carry), 2);
    drive(0, 0, 0, '0, '0);
    drive(0, 0, 0, '0, '0);
    chk("R3 hold state", 32'(state), 32'hace1);
    chk("R3 hold carry", 32'(carry), 2);
    drive(0, 1, 0, '0, '0);
    chk("R7 lockup on zero load", 32'(lockup), 1);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, '0, '0);
    chk("R7 lockup persists", 32'(lockup), 1);
    check_all("zero");
    drive(0, 1, 0, 16'h0000, 3'd7);
    chk("R7 no lockup with carry", 32'(lockup), 0);
    for (int i = 0; i < 40; i++) begin
      drive(0, 0, 1, '0, '0);
      check_all("bigcarry");
      chk("R8 no wrap", 32'(carry <= 7), 1);
    end
    chk("R8 carry settles", 32'(carry <= NT), 1);
    for (int s = 0; s < 5; s++) begin
      drive(0, 1, 0, 16'($urandom), CW'($urandom_range(0, NT)));
      check_all("seed");
      for (int i = 0; i < 1000; i++) begin
        logic l = ($urandom_range(0, 99) == 0);
        logic e = ($urandom_range(0, 3) != 0);
        drive(0, l, e, 16'($urandom), CW'($urandom_range(0, 7)));
        check_all("rand");
        if (!l && m_carry <= NT) chk("R8 bound", 32'(carry <= NT), 1);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule